// File: doc/BRIEF.md
# Mixed-Radix Timestamp Counter

This block keeps a free-running time-of-day style timestamp in hardware. A prescaler turns the system clock into a one-microsecond enable. That enable drives a chain of counter stages. The first stage counts microseconds within a millisecond. The second counts milliseconds within a second. The third counts seconds within a minute. A final binary counter accumulates whole minutes. Every stage is a plain modulo counter in its own radix, so each field reads directly in its natural unit and needs no division downstream.

Capture logic elsewhere on the chip samples one packed word that holds the seconds, milliseconds and microseconds fields. All three fields are registers that update on the same clock edge, so a sampled word never shows a carry that has reached one field but not the next. Each stage also drives a square wave with a 50% duty cycle at its own wrap rate. When the seconds stage wraps, the block raises a one-cycle minute pulse and sets a sticky flag that software-facing logic can clear.

An enable input stops all counting, including the prescaler phase, and keeps every value. A synchronous active-low reset returns everything to zero.

Top module: `ts_timestamp`

## Requirements
- R1: While rst_n is low at a clock edge, the prescaler, all stage counters, the minute count, the three waves, the pulse and the flag become zero at that edge.
- R2: While run_i is high, the microsecond field advances once every PRESCALE clock cycles (default 150), and the first advance after reset comes on the PRESCALE-th running edge.
- R3: The microsecond field, stamp_o[9:0], counts 0 to US_MOD-1 (default 999) and then returns to 0 on its next advance.
- R4: The millisecond field, stamp_o[19:10], changes only on the edge where the microsecond field returns to 0. It counts 0 to MS_MOD-1 (default 999) and then wraps to 0.
- R5: The seconds field, stamp_o[25:20], changes only on the edge where the millisecond field wraps. It counts 0 to S_MOD-1 (default 59) and then wraps to 0.
- R6: minutes_o increments by one, modulo 2^MIN_W, on the edge where the seconds field wraps.
- R7: min_pulse_o is high for exactly the one cycle that follows the edge at which the seconds field wraps. At all other times it is low.
- R8: min_flag_o is set by the same edge that raises min_pulse_o. It stays set until an edge at which flag_clr_i is high and no new wrap occurs. A wrap on the same edge as a clear leaves the flag set.
- R9: Each wave output (us_wave_o, ms_wave_o, s_wave_o) is high exactly when its stage's count is at least half of that stage's modulus (500 of 1000, or 30 of 60). It is low otherwise.
- R10: While run_i is low, the prescaler phase, all fields, minutes_o, the waves and the flag hold their values. Counting resumes from the same phase once run_i returns high.
- R11: The packed word places seconds in bits [25:20], milliseconds in bits [19:10] and microseconds in bits [9:0]. All three fields reflect the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Counting enable; low freezes all state |
| flag_clr_i | input | 1 | Clears the sticky minute flag |
| stamp_o | output | 26 | Packed seconds / milliseconds / microseconds word |
| minutes_o | output | MIN_W (16) | Whole minutes elapsed, wrapping |
| us_wave_o | output | 1 | Square wave at the millisecond rate |
| ms_wave_o | output | 1 | Square wave at the second rate |
| s_wave_o | output | 1 | Square wave at the minute rate |
| min_pulse_o | output | 1 | One-cycle pulse on each seconds wrap |
| min_flag_o | output | 1 | Sticky record of a seconds wrap |

## Verification
The hardest situation to reach from the ports is the full carry ripple that wraps the seconds stage. With default parameters this takes nine billion clock cycles. It is also where a clear on the flag can coincide with a new wrap. The bench therefore builds the block with small moduli and a short prescale, so a minute passes in a few hundred cycles. It then holds the clear input high across several minute boundaries, and toggles the run input rapidly around wraps. A behavioural reference model is compared against every output on every cycle.

// File: rtl/ts_pkg.sv
// Shared field layout of the packed timestamp word.
// Assumes: the field widths are fixed by the consumers that decode the word.
package ts_pkg;

    localparam int US_FW   = 10;
    localparam int MS_FW   = 10;
    localparam int S_FW    = 6;
    localparam int STAMP_W = US_FW + MS_FW + S_FW;

    // Most significant field first: seconds [25:20], ms [19:10], us [9:0].
    typedef struct packed {
        logic [S_FW-1:0]  sec;
        logic [MS_FW-1:0] msec;
        logic [US_FW-1:0] usec;
    } stamp_t;

endpackage

// File: rtl/ts_prescaler.sv
// Divides the system clock into a single-cycle tick every PRESCALE cycles.
// Assumes: PRESCALE >= 1; the phase is held while run_i is low.
module ts_prescaler #(
    parameter int PRESCALE = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] phase_q;

    assign tick_o = run_i && (phase_q == LAST);

    // Advance the division phase while running, restart after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (run_i) begin
            if (phase_q == LAST) phase_q <= '0;
            else                 phase_q <= phase_q + PW'(1);
        end
    end

    AST_PRE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(phase_q)); // R10

    generate
        if (PRESCALE > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R2
        end
    endgenerate

endmodule

// File: rtl/ts_stage.sv
// One modulo-MOD counting stage with its half-period square wave.
// Assumes: 2 <= MOD <= 2**W; adv_i is the single-cycle advance strobe.
module ts_stage #(
    parameter int MOD = 1000,
    parameter int W   = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic [W-1:0] cnt_o,
    output logic         wave_o,
    output logic         carry_o
);

    localparam logic [W-1:0] LAST = W'(MOD - 1);
    localparam logic [W-1:0] HALF = W'(MOD / 2);

    logic [W-1:0] cnt_q;
    logic         wave_q;

    assign cnt_o   = cnt_q;
    assign wave_o  = wave_q;
    assign carry_o = adv_i && (cnt_q == LAST);

    // Count on each advance; raise the wave at half, drop it at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
        end else if (adv_i) begin
            if (cnt_q == LAST) begin
                cnt_q  <= '0;
                wave_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + W'(1);
                if (cnt_q + W'(1) == HALF) wave_q <= 1'b1;
            end
        end
    end

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R3

    AST_WAVE_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wave_q == (cnt_q >= HALF)); // R9

    AST_CARRY_RETURNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> (cnt_q == '0)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/ts_minute.sv
// Whole-minute counter with a one-cycle pulse and a sticky flag.
// Assumes: adv_i is the seconds-stage carry and is never high two cycles running.
module ts_minute #(
    parameter int MIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             clr_i,
    output logic [MIN_W-1:0] minutes_o,
    output logic             pulse_o,
    output logic             flag_o
);

    logic [MIN_W-1:0] min_q;
    logic             pulse_q;
    logic             flag_q;

    assign minutes_o = min_q;
    assign pulse_o   = pulse_q;
    assign flag_o    = flag_q;

    // Count minutes and register the wrap strobe as a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= adv_i;
            if (adv_i) min_q <= min_q + MIN_W'(1);
        end
    end

    // Sticky flag: a new wrap wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (adv_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q); // R8

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> flag_q); // R8

    AST_MIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (min_q == $past(min_q) + MIN_W'(1))); // R6

endmodule

// File: rtl/ts_timestamp.sv
// Top: prescaler feeding a microsecond / millisecond / second cascade and a
// minute counter. Presents the three sub-minute fields as one packed word.
// Assumes: each modulus fits its field width in ts_pkg; S_MOD >= 2.
module ts_timestamp
    import ts_pkg::*;
#(
    parameter int PRESCALE = 150,
    parameter int US_MOD   = 1000,
    parameter int MS_MOD   = 1000,
    parameter int S_MOD    = 60,
    parameter int MIN_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               flag_clr_i,
    output logic [STAMP_W-1:0] stamp_o,
    output logic [MIN_W-1:0]   minutes_o,
    output logic               us_wave_o,
    output logic               ms_wave_o,
    output logic               s_wave_o,
    output logic               min_pulse_o,
    output logic               min_flag_o
);

    logic   tick;
    logic   us_carry, ms_carry, s_carry;
    stamp_t stamp;

    ts_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_i),
        .tick_o (tick)
    );

    ts_stage #(.MOD(US_MOD), .W(US_FW)) u_us (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (tick),
        .cnt_o   (stamp.usec),
        .wave_o  (us_wave_o),
        .carry_o (us_carry)
    );

    ts_stage #(.MOD(MS_MOD), .W(MS_FW)) u_ms (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (us_carry),
        .cnt_o   (stamp.msec),
        .wave_o  (ms_wave_o),
        .carry_o (ms_carry)
    );

    ts_stage #(.MOD(S_MOD), .W(S_FW)) u_s (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (ms_carry),
        .cnt_o   (stamp.sec),
        .wave_o  (s_wave_o),
        .carry_o (s_carry)
    );

    ts_minute #(.MIN_W(MIN_W)) u_min (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (s_carry),
        .clr_i     (flag_clr_i),
        .minutes_o (minutes_o),
        .pulse_o   (min_pulse_o),
        .flag_o    (min_flag_o)
    );

    assign stamp_o = stamp;

    AST_MS_ON_US_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stamp_o[19:10]) |-> ($past(stamp_o[9:0]) == US_FW'(US_MOD - 1))); // R4

    AST_S_ON_MS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stamp_o[25:20]) |-> ($past(stamp_o[19:10]) == MS_FW'(MS_MOD - 1))); // R5

    AST_PULSE_ON_S_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        min_pulse_o |-> (stamp_o[25:20] == '0 && $past(stamp_o[25:20]) == S_FW'(S_MOD - 1))); // R7

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ($stable(stamp_o) && $stable(minutes_o))); // R10

endmodule

// File: tb/ts_timestamp_tb_top.sv
// Bench: behavioural reference model compared against every output each cycle.
module ts_timestamp_tb_top;

    localparam int P  = 3;
    localparam int UM = 10;
    localparam int MM = 4;
    localparam int SM = 6;
    localparam int MW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        flag_clr_i = 1'b0;
    logic [25:0] stamp_o;
    logic [MW-1:0] minutes_o;
    logic        us_wave_o, ms_wave_o, s_wave_o, min_pulse_o, min_flag_o;

    always #4 clk = ~clk;

    ts_timestamp #(
        .PRESCALE(P), .US_MOD(UM), .MS_MOD(MM), .S_MOD(SM), .MIN_W(MW)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .flag_clr_i  (flag_clr_i),
        .stamp_o     (stamp_o),
        .minutes_o   (minutes_o),
        .us_wave_o   (us_wave_o),
        .ms_wave_o   (ms_wave_o),
        .s_wave_o    (s_wave_o),
        .min_pulse_o (min_pulse_o),
        .min_flag_o  (min_flag_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference state.
    int m_pre = 0, m_us = 0, m_ms = 0, m_s = 0, m_min = 0;
    int m_pulse = 0, m_flag = 0, wraps_seen = 0, clr_wraps = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Advance the model by one clock edge using the inputs held during it.
    task automatic model_edge();
        int pulse_now = 0;
        if (!rst_n) begin
            m_pre = 0; m_us = 0; m_ms = 0; m_s = 0; m_min = 0;
            m_pulse = 0; m_flag = 0;
            return;
        end
        if (run_i) begin
            if (m_pre == P - 1) begin
                m_pre = 0;
                m_us++;
                if (m_us == UM) begin
                    m_us = 0; m_ms++;
                    if (m_ms == MM) begin
                        m_ms = 0; m_s++;
                        if (m_s == SM) begin
                            m_s = 0;
                            m_min = (m_min + 1) % (1 << MW);
                            pulse_now = 1;
                        end
                    end
                end
            end else begin
                m_pre++;
            end
        end
        if (pulse_now) begin
            wraps_seen++;
            if (flag_clr_i) clr_wraps++;
            m_flag = 1;
        end else if (flag_clr_i) begin
            m_flag = 0;
        end
        m_pulse = pulse_now;
    endtask

    task automatic compare();
        string sfx;
        sfx = !rst_n ? " R1" : (!run_i ? " R10" : "");
        check(stamp_o[9:0] == m_us,   {"R2 R3 usec", sfx}, stamp_o[9:0], m_us);
        check(stamp_o[19:10] == m_ms, {"R4 R11 msec", sfx}, stamp_o[19:10], m_ms);
        check(stamp_o[25:20] == m_s,  {"R5 R11 sec", sfx}, stamp_o[25:20], m_s);
        check(minutes_o == m_min,     {"R6 minutes", sfx}, minutes_o, m_min);
        check(us_wave_o == (m_us >= UM / 2), {"R9 us wave", sfx}, us_wave_o, m_us >= UM / 2);
        check(ms_wave_o == (m_ms >= MM / 2), {"R9 ms wave", sfx}, ms_wave_o, m_ms >= MM / 2);
        check(s_wave_o == (m_s >= SM / 2),   {"R9 s wave", sfx}, s_wave_o, m_s >= SM / 2);
        check(min_pulse_o == m_pulse, {"R7 pulse", sfx}, min_pulse_o, m_pulse);
        check(min_flag_o == m_flag,   {"R8 flag", sfx}, min_flag_o, m_flag);
    endtask

    // One cycle: drive inputs at the falling edge, model the rising edge, compare after it.
    task automatic step(input bit rst, input bit run, input bit clr);
        rst_n = rst;
        run_i = run;
        flag_clr_i = clr;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state, with run and clear both active.
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1);
        // R2..R9: free running across several minutes.
        for (int i = 0; i < 3000; i++) step(1'b1, 1'b1, 1'b0);
        // R10: run toggled every few cycles.
        for (int i = 0; i < 1200; i++) step(1'b1, (i % 7) < 4, 1'b0);
        // R8: periodic clear pulses.
        for (int i = 0; i < 1500; i++) step(1'b1, 1'b1, (i % 50) == 0);
        // R8: clear held high across minute wraps (set must win).
        for (int i = 0; i < 1600; i++) step(1'b1, 1'b1, 1'b1);
        // R1: reset in mid count, then resume.
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 900; i++) step(1'b1, 1'b1, 1'b0);
        // R10: long freeze with clear low keeps the flag.
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b0);
        // R7 R8: coverage of wraps, including wraps under a held clear.
        check(wraps_seen >= 8, "R7 minute wraps reached", wraps_seen, 8);
        check(clr_wraps >= 2, "R8 wraps coinciding with clear", clr_wraps, 2);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

endmodule